// File: doc/BRIEF.md
# Fixed-Point Rounding Right-Shift Lane

This block is one lane of a vector datapath that divides an element by a power of two with rounding. It accepts a 32-bit instruction word, one element value, a vector operand, a scalar operand, an element-width select and a two-bit rounding mode. The instruction word chooses logical or arithmetic shifting and where the shift count comes from. The count can come from the vector operand, the scalar operand or a 5-bit field inside the instruction. The element is shifted right, and a 0/1 increment is added to the result. The rounding mode picks that increment from the bits that were shifted out.

The lane computes the result combinationally and registers it once. The result therefore appears one clock after a request. A word that does not decode as one of the six supported forms raises a one-cycle illegal flag and produces no result. The caller supplies the register file, element masking and vector length control.

Top module: `vsshift_unit`

## Requirements
- R1: A request decodes only when instr[6:0] is 1010111, instr[31:26] is 101010 (logical) or 101011 (arithmetic), and instr[14:12] is 000, 100 or 011. Any other word raises out_illegal for one cycle, and out_valid stays low.
- R2: The shift count comes from vec_opnd when instr[14:12] is 000, from scl_opnd when it is 100, and from the immediate in instr[19:15] when it is 011.
- R3: The logical form zero-extends the immediate to 64 bits. The arithmetic form sign-extends it. Masking to the element width happens after the extension, so immediate 10000 at 64-bit width shifts by 16 (logical) or by 48 (arithmetic).
- R4: width_sel 00, 01, 10 and 11 select 8-, 16-, 32- and 64-bit elements. Only the low 3, 4, 5 or 6 bits of the count are used. Element bits above the width are ignored, and result bits above the width are zero.
- R5: The logical form treats the element as unsigned and fills with zeros from the top.
- R6: The arithmetic form treats the element as signed and fills with copies of its sign bit.
- R7: With round_mode 00, the increment is the last bit shifted out, bit[s-1], where s is the masked count.
- R8: With round_mode 01, the increment is bit[s-1] AND (any of bits[s-2:0] OR bit[s]). A tie therefore rounds to an even result.
- R9: With round_mode 10, the increment is always 0, so the result is truncated.
- R10: With round_mode 11, the increment is NOT bit[s] AND (any of bits[s-1:0]). This forces the result odd whenever any bit is discarded.
- R11: A masked count of 0 returns the element unchanged in every mode.
- R12: result, out_valid and out_illegal change one clock after the request. Synchronous reset clears all three, and result holds its value on cycles with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| instr | input | 32 | Instruction word to decode |
| elem_in | input | 64 | Element value, right-aligned |
| vec_opnd | input | 64 | Shift count source for vector-vector form |
| scl_opnd | input | 64 | Shift count source for vector-scalar form |
| width_sel | input | 2 | Element width select |
| round_mode | input | 2 | Rounding mode |
| out_valid | output | 1 | Result valid, one cycle after request |
| out_illegal | output | 1 | Request word did not decode |
| result | output | 64 | Rounded shifted element, zero above width |

## Verification
Most internal faults here, such as a wrong guard bit, sticky bit, count mask or fill bit, corrupt the result of the very request that exercises them. They show up in the next cycle as a one-LSB error or as a grossly wrong value. A decode fault instead swaps out_valid with out_illegal, or changes which operand is used, and is seen on the same one-cycle schedule. The stimulus drives each width with all-ones and most-negative elements and with the largest count, in every mode and both signednesses. Without these cases, faults that only touch the top bit position or the sign fill would stay hidden.

// File: rtl/vss_pkg.sv
`timescale 1ns/1ps
package vss_pkg;
  localparam logic [6:0] OPC_VEC    = 7'b1010111;
  localparam logic [5:0] F6_LOGICAL = 6'b101010;
  localparam logic [5:0] F6_ARITH   = 6'b101011;
  localparam logic [2:0] F3_VV      = 3'b000;
  localparam logic [2:0] F3_VX      = 3'b100;
  localparam logic [2:0] F3_VI      = 3'b011;
  localparam int         IMM_W      = 5;

  typedef enum logic [1:0] {
    SRC_VEC = 2'd0,
    SRC_SCL = 2'd1,
    SRC_IMM = 2'd2
  } opnd_src_e;

  typedef enum logic [1:0] {
    RM_NEAR_UP   = 2'd0,
    RM_NEAR_EVEN = 2'd1,
    RM_TRUNC     = 2'd2,
    RM_JAM_ODD   = 2'd3
  } rmode_e;

  typedef struct packed {
    logic      legal;
    logic      arith;
    opnd_src_e src;
  } dec_t;
endpackage

// File: rtl/vss_decode.sv
`timescale 1ns/1ps
module vss_decode
  import vss_pkg::*;
#(
  parameter int MAX_W = 64
) (
  input  logic [31:0]      instr,
  output dec_t             dec,
  output logic [MAX_W-1:0] imm_ext
);
  logic [6:0] opc;
  logic [5:0] f6;
  logic [2:0] f3;
  logic [IMM_W-1:0] imm;
  logic op_ok, f6_ok;

  assign opc = instr[6:0];
  assign f6  = instr[31:26];
  assign f3  = instr[14:12];
  assign imm = instr[19:15];

  assign op_ok = (opc == OPC_VEC);
  assign f6_ok = (f6 == F6_LOGICAL) || (f6 == F6_ARITH);

  always_comb begin
    dec.arith = (f6 == F6_ARITH);
    dec.src   = SRC_VEC;
    dec.legal = 1'b0;
    unique case (f3)
      F3_VV: begin dec.src = SRC_VEC; dec.legal = op_ok && f6_ok; end
      F3_VX: begin dec.src = SRC_SCL; dec.legal = op_ok && f6_ok; end
      F3_VI: begin dec.src = SRC_IMM; dec.legal = op_ok && f6_ok; end
      default: begin dec.src = SRC_VEC; dec.legal = 1'b0; end
    endcase
  end

  // R3: sign- or zero-extend the immediate before any width masking
  assign imm_ext = dec.arith ? {{(MAX_W-IMM_W){imm[IMM_W-1]}}, imm}
                             : {{(MAX_W-IMM_W){1'b0}}, imm};
endmodule

// File: rtl/vss_opnd_sel.sv
`timescale 1ns/1ps
module vss_opnd_sel
  import vss_pkg::*;
#(
  parameter int MAX_W = 64
) (
  input  opnd_src_e        src,
  input  logic [MAX_W-1:0] vec_opnd,
  input  logic [MAX_W-1:0] scl_opnd,
  input  logic [MAX_W-1:0] imm_ext,
  output logic [MAX_W-1:0] count_raw
);
  always_comb begin
    unique case (src)
      SRC_SCL: count_raw = scl_opnd;
      SRC_IMM: count_raw = imm_ext;
      default: count_raw = vec_opnd;
    endcase
  end
endmodule

// File: rtl/vss_lane.sv
`timescale 1ns/1ps
module vss_lane
  import vss_pkg::*;
#(
  parameter int W     = 8,
  parameter int MAX_W = 64
) (
  input  logic [MAX_W-1:0] elem,
  input  logic [MAX_W-1:0] count_raw,
  input  logic             arith,
  input  rmode_e           rmode,
  output logic [MAX_W-1:0] res
);
  localparam int SW = $clog2(W);

  logic [W-1:0]  v;
  logic [SW-1:0] s;
  logic [W-1:0]  shifted;
  logic [W-1:0]  below_mask;
  logic [W-1:0]  guard_mask;
  logic [W-1:0]  sticky_mask;
  logic [W-1:0]  lsb_mask;
  logic          nz;
  logic          guard_b, sticky_b, lsb_b, dropped_b;
  logic          inc;
  logic [W-1:0]  sum;

  assign v  = elem[W-1:0];
  // R4: only log2(W) low bits of the count are used
  assign s  = count_raw[SW-1:0];
  assign nz = (s != '0);

  // R5 / R6: zero fill or sign fill
  assign shifted = arith ? W'($signed(v) >>> s) : (v >> s);

  assign lsb_mask    = W'(1) << s;
  assign below_mask  = lsb_mask - W'(1);
  assign guard_mask  = nz ? (W'(1) << (s - SW'(1))) : '0;
  assign sticky_mask = nz ? (guard_mask - W'(1)) : '0;

  assign guard_b   = |(v & guard_mask);
  assign sticky_b  = |(v & sticky_mask);
  assign lsb_b     = |(v & lsb_mask);
  assign dropped_b = |(v & below_mask);

  // R7..R10: increment picked by rounding mode
  always_comb begin
    unique case (rmode)
      RM_NEAR_UP:   inc = guard_b;
      RM_NEAR_EVEN: inc = guard_b & (sticky_b | lsb_b);
      RM_TRUNC:     inc = 1'b0;
      RM_JAM_ODD:   inc = ~lsb_b & dropped_b;
      default:      inc = 1'b0;
    endcase
  end

  assign sum = shifted + W'(inc);

  generate
    if (W == MAX_W) begin : g_full
      assign res = sum;
    end else begin : g_narrow
      assign res = {{(MAX_W-W){1'b0}}, sum};
    end
  endgenerate

  always_comb begin
    // R11
    inc_needs_discard_chk: assert (!inc || dropped_b);
    // R9
    trunc_no_inc_chk: assert (!(rmode == RM_TRUNC && inc));
  end
endmodule

// File: rtl/vsshift_unit.sv
`timescale 1ns/1ps
module vsshift_unit
  import vss_pkg::*;
#(
  parameter int MAX_W = 64,
  parameter int MIN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [31:0]      instr,
  input  logic [MAX_W-1:0] elem_in,
  input  logic [MAX_W-1:0] vec_opnd,
  input  logic [MAX_W-1:0] scl_opnd,
  input  logic [1:0]       width_sel,
  input  logic [1:0]       round_mode,
  output logic             out_valid,
  output logic             out_illegal,
  output logic [MAX_W-1:0] result
);
  localparam int NW = $clog2(MAX_W / MIN_W) + 1;

  dec_t             dec;
  logic [MAX_W-1:0] imm_ext;
  logic [MAX_W-1:0] count_raw;
  logic [MAX_W-1:0] lane_res [NW];
  logic [MAX_W-1:0] sel_res;
  rmode_e           rm;

  assign rm = rmode_e'(round_mode);

  vss_decode #(.MAX_W(MAX_W)) u_dec (
    .instr   (instr),
    .dec     (dec),
    .imm_ext (imm_ext)
  );

  vss_opnd_sel #(.MAX_W(MAX_W)) u_sel (
    .src       (dec.src),
    .vec_opnd  (vec_opnd),
    .scl_opnd  (scl_opnd),
    .imm_ext   (imm_ext),
    .count_raw (count_raw)
  );

  generate
    for (genvar gi = 0; gi < NW; gi++) begin : g_lane
      vss_lane #(.W(MIN_W << gi), .MAX_W(MAX_W)) u_lane (
        .elem      (elem_in),
        .count_raw (count_raw),
        .arith     (dec.arith),
        .rmode     (rm),
        .res       (lane_res[gi])
      );
    end
  endgenerate

  assign sel_res = lane_res[width_sel];

  // R12: single output register stage
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      result      <= '0;
    end else begin
      out_valid   <= in_valid & dec.legal;
      out_illegal <= in_valid & ~dec.legal;
      if (in_valid & dec.legal) result <= sel_res;
    end
  end

  // R12
  valid_after_request_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));
  // R1
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({out_valid, out_illegal}));
  // R4
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(width_sel) == 2'd0) |-> (result[MAX_W-1:MIN_W] == '0));
  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));
endmodule

// File: tb/vsshift_unit_bench.sv
`timescale 1ns/1ps
module vsshift_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] elem_in = '0, vec_opnd = '0, scl_opnd = '0;
  logic [1:0]  width_sel = '0, round_mode = '0;
  logic        out_valid, out_illegal;
  logic [63:0] result;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vsshift_unit u_vsshift_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .elem_in(elem_in), .vec_opnd(vec_opnd), .scl_opnd(scl_opnd),
    .width_sel(width_sel), .round_mode(round_mode),
    .out_valid(out_valid), .out_illegal(out_illegal), .result(result)
  );

  localparam logic [5:0] LOG = 6'b101010, ARI = 6'b101011;
  localparam logic [2:0] VV = 3'b000, VX = 3'b100, VI = 3'b011;

  function automatic logic [31:0] mk(input logic [5:0] f6, input logic [2:0] f3,
                                     input logic [4:0] fld);
    return {f6, 1'b1, 5'd2, fld, f3, 5'd3, 7'b1010111};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // independent reference built from the requirement text
  function automatic logic [63:0] ref_fn(input bit ari, input int wsel,
      input logic [63:0] e, input logic [63:0] cnt, input logic [1:0] rm);
    int w = 8 << wsel;
    logic [63:0] msk = (w == 64) ? '1 : ((64'd1 << w) - 1);
    int s = int'(cnt & 64'(w - 1));
    logic [63:0] x = e & msk;
    logic [63:0] sh;
    logic g, st, lsb, any, inc;
    if (ari && x[w-1]) x = x | ~msk;
    sh  = ari ? 64'($signed(x) >>> s) : (x >> s);
    g   = (s > 0) ? x[s-1] : 1'b0;
    st  = 1'b0;
    for (int i = 0; i < s - 1; i++) st |= x[i];
    lsb = x[s];
    any = g | st;
    case (rm)
      2'd0: inc = g;
      2'd1: inc = g & (st | lsb);
      2'd2: inc = 1'b0;
      default: inc = ~lsb & any;
    endcase
    return (sh + 64'(inc)) & msk;
  endfunction

  task automatic issue(input logic [31:0] ins, input logic [63:0] e, v, sc,
                       input logic [1:0] w, rm);
    @(negedge clk);
    instr = ins; elem_in = e; vec_opnd = v; scl_opnd = sc;
    width_sel = w; round_mode = rm; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_ref(input string tag, input logic [5:0] f6, input logic [2:0] f3,
      input logic [4:0] imm, input logic [63:0] e, v, sc, input logic [1:0] w, rm);
    logic [63:0] cnt;
    bit ari = (f6 == ARI);
    if (f3 == VV) cnt = v;
    else if (f3 == VX) cnt = sc;
    else cnt = ari ? {{59{imm[4]}}, imm} : {59'd0, imm};
    issue(mk(f6, f3, imm), e, v, sc, w, rm);
    check({tag, " valid"}, {63'd0, out_valid}, 64'd1);
    check(tag, result, ref_fn(ari, int'(w), e, cnt, rm));
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R12 reset valid", {63'd0, out_valid}, 64'd0);
    check("R12 reset illegal", {63'd0, out_illegal}, 64'd0);
    check("R12 reset result", result, 64'd0);
  endtask

  task automatic t_decode;
    issue({LOG, 1'b1, 5'd2, 5'd1, VX, 5'd3, 7'b0110011}, 64'h80, 0, 1, 2'd0, 2'd2);
    check("R1 bad opcode illegal", {63'd0, out_illegal}, 64'd1);
    check("R1 bad opcode valid", {63'd0, out_valid}, 64'd0);
    issue(mk(LOG, 3'b001, 5'd1), 64'h80, 0, 1, 2'd0, 2'd2);
    check("R1 bad funct3 illegal", {63'd0, out_illegal}, 64'd1);
    issue(mk(6'b101000, VV, 5'd1), 64'h80, 1, 1, 2'd0, 2'd2);
    check("R1 bad funct6 illegal", {63'd0, out_illegal}, 64'd1);
    issue(mk(ARI, VV, 5'd1), 64'h80, 1, 1, 2'd0, 2'd2);
    check("R1 good illegal low", {63'd0, out_illegal}, 64'd0);
    check("R1 good result", result, 64'hC0);
  endtask

  task automatic t_source;
    issue(mk(LOG, VV, 5'd1), 64'h80, 64'd3, 64'd1, 2'd0, 2'd2);
    check("R2 vector operand", result, 64'h10);
    issue(mk(LOG, VX, 5'd3), 64'h80, 64'd3, 64'd1, 2'd0, 2'd2);
    check("R2 scalar operand", result, 64'h40);
    issue(mk(LOG, VI, 5'd2), 64'h80, 64'd3, 64'd1, 2'd0, 2'd2);
    check("R2 immediate operand", result, 64'h20);
  endtask

  task automatic t_imm_ext;
    issue(mk(LOG, VI, 5'b10000), 64'h8000_0000_0000_0000, 0, 0, 2'd3, 2'd2);
    check("R3 zero-extended imm", result, 64'h0000_8000_0000_0000);
    issue(mk(ARI, VI, 5'b10000), 64'h8000_0000_0000_0000, 0, 0, 2'd3, 2'd2);
    check("R3 sign-extended imm", result, 64'hFFFF_FFFF_FFFF_8000);
  endtask

  task automatic t_width;
    issue(mk(LOG, VX, 0), 64'hFFFF_FFFF_FFFF_FF10, 0, 64'hFFFF_FFFF_FFFF_FFF9, 2'd0, 2'd0);
    check("R4 8-bit mask and upper zero", result, 64'h08);
    issue(mk(ARI, VX, 0), 64'h1234_5678_9ABC_8000, 0, 64'h31, 2'd1, 2'd2);
    check("R4 16-bit sign fill", result, 64'hC000);
    issue(mk(LOG, VX, 0), 64'hFFFF_FFFF_0000_0001, 0, 64'h3F, 2'd2, 2'd0);
    check("R4 32-bit max count", result, 64'h0);
  endtask

  task automatic t_fill;
    issue(mk(LOG, VX, 0), 64'h80, 0, 64'd3, 2'd0, 2'd2);
    check("R5 zero fill", result, 64'h10);
    issue(mk(ARI, VX, 0), 64'h80, 0, 64'd3, 2'd0, 2'd2);
    check("R6 sign fill", result, 64'hF0);
  endtask

  task automatic t_modes;
    issue(mk(LOG, VX, 0), 64'h24, 0, 64'd3, 2'd0, 2'd0);
    check("R7 near-up tie", result, 64'h05);
    issue(mk(LOG, VX, 0), 64'h24, 0, 64'd3, 2'd0, 2'd1);
    check("R8 tie to even stays", result, 64'h04);
    issue(mk(LOG, VX, 0), 64'h2C, 0, 64'd3, 2'd0, 2'd1);
    check("R8 tie to even rounds", result, 64'h06);
    issue(mk(LOG, VX, 0), 64'h2C, 0, 64'd3, 2'd0, 2'd2);
    check("R9 truncate", result, 64'h05);
    issue(mk(LOG, VX, 0), 64'h24, 0, 64'd3, 2'd0, 2'd3);
    check("R10 jam odd sets", result, 64'h05);
    issue(mk(LOG, VX, 0), 64'h2C, 0, 64'd3, 2'd0, 2'd3);
    check("R10 jam odd already odd", result, 64'h05);
  endtask

  task automatic t_zero_shift;
    for (int m = 0; m < 4; m++) begin
      issue(mk(ARI, VX, 0), 64'hA5, 0, 64'h40, 2'd0, 2'(m));
      check("R11 zero count unchanged", result, 64'hA5);
    end
  endtask

  task automatic t_timing;
    issue(mk(LOG, VX, 0), 64'h40, 0, 64'd1, 2'd0, 2'd2);
    check("R12 result after one clock", result, 64'h20);
    @(negedge clk);
    check("R12 valid drops", {63'd0, out_valid}, 64'd0);
    check("R12 result holds", result, 64'h20);
  endtask

  task automatic t_edges;
    for (int w = 0; w < 4; w++)
      for (int m = 0; m < 4; m++)
        for (int a = 0; a < 2; a++) begin
          logic [5:0] f6 = a ? ARI : LOG;
          logic [63:0] mneg = 64'd1 << ((8 << w) - 1);
          run_ref("R4 R7 R8 R9 R10 all-ones", f6, VX, 0, '1, 0, 64'd5, 2'(w), 2'(m));
          run_ref("R6 R7 R8 R9 R10 most-negative", f6, VX, 0, mneg, 0, 64'd3, 2'(w), 2'(m));
          run_ref("R4 R5 R6 max count", f6, VV, 0, {$urandom, $urandom}, '1, 0, 2'(w), 2'(m));
        end
  endtask

  task automatic t_random;
    for (int k = 0; k < 500; k++) begin
      logic [2:0] f3s [3] = '{VV, VX, VI};
      run_ref("R2 R5 R6 R7 R8 R9 R10 random", ($urandom & 1) ? ARI : LOG,
              f3s[$urandom % 3], 5'($urandom), {$urandom, $urandom},
              64'($urandom), 64'($urandom), 2'($urandom), 2'($urandom));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_decode;
    t_source;
    t_imm_ext;
    t_width;
    t_fill;
    t_modes;
    t_zero_shift;
    t_timing;
    t_edges;
    t_random;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule